// File: doc/BRIEF.md
# Ordered Multi-Domain Reset Sequencer

This block takes one active-low board reset and turns it into a separate master reset for each of several unrelated clock domains. When the board reset goes low, every domain reset goes low at once, whether or not any clock is running. When the board reset goes high, each domain leaves reset through its own chain of two flops clocked by that domain's clock. Each domain therefore releases on a clean edge of its own clock, and the chain absorbs any metastability caused by a release that lands close to an edge.

By default the chains are cascaded. The first domain's chain is fed a constant one. Every later domain's chain is fed the master reset of the domain before it. As a result the domains leave reset strictly in index order: domain 0, then 1, then 2. A configuration input selects unordered release instead. In that mode every chain is fed a constant one and each domain releases on its own schedule. A test-mode input holds every domain reset inactive so that scan shifting is never disturbed.

Top module: `reset_sequencer`

## Requirements
- R1: While `ext_rst_n` is low and `test_mode` is low, every bit of `dom_rst_n` is low. This follows from the falling edge of `ext_rst_n` with no clock edge required.
- R2: Domain k's release needs two rising edges of `dom_clk[k]` after its trigger. After the first of these edges `dom_rst_n[k]` is still low. After the second it is high.
- R3: With ordered release (`ordered_mode` = 1 held during reset), the trigger for domain 0 is the rise of `ext_rst_n`. The trigger for domain k > 0 is the rise of `dom_rst_n[k-1]`. Domains therefore release in the order 0, 1, 2.
- R4: With unordered release (`ordered_mode` = 0 held during reset), the trigger for every domain is the rise of `ext_rst_n`.
- R5: While `test_mode` is 1, every bit of `dom_rst_n` is high, even while `ext_rst_n` is low. Dropping `test_mode` to 0 exposes the internal reset state again.
- R6: A new low on `ext_rst_n` in the middle of a release sequence immediately pulls every domain back to reset. The next release then starts again from the first flop of every chain.
- R7: Each domain samples `ordered_mode` on its own clock only while its first chain flop is still in reset. Changing `ordered_mode` after release has no effect on `dom_rst_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ext_rst_n | input | 1 | Board reset, active low, asynchronous |
| dom_clk | input | DOMAINS | One clock per domain; bit k clocks domain k |
| ordered_mode | input | 1 | 1 selects cascaded release in index order, 0 selects independent release |
| test_mode | input | 1 | 1 holds every domain reset inactive |
| dom_rst_n | output | DOMAINS | Master reset per domain, active low |

## Verification
Two events can coincide. One is the board reset being asserted again. The other is a release that is still moving down the cascade: domain 0 has just left reset while domains 1 and 2 are still inside their chains. The bench provokes this by waiting for the rise of domain 0's reset and asserting the board reset a fraction of a nanosecond later. It then expects every domain reset to read low right away, and expects a clean two-edge release per domain on the next deassertion. Release order and edge counts are judged against edge counts of each domain's own clock. The clock frequencies are random and the phases are offset, so that no two domains ever share an edge.

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
  parameter int DOMAINS = 3,
  parameter int STAGES  = 2
) (
  input  logic               ext_rst_n,
  input  logic [DOMAINS-1:0] dom_clk,
  input  logic               ordered_mode,
  input  logic               test_mode,
  output logic [DOMAINS-1:0] dom_rst_n
);
  timeunit 1ns;
  timeprecision 10ps;

  localparam int LAST = STAGES - 1;

  logic [DOMAINS-1:0] rel;

  for (genvar i = 0; i < DOMAINS; i++) begin : g_dom
    logic [STAGES-1:0] chain;
    logic              feed;
    logic              mode_q;

    if (i == 0) begin : g_head
      assign feed = 1'b1;
    end else begin : g_tail
      assign feed = mode_q ? rel[i-1] : 1'b1;

      assert_order_R3: assert property (@(posedge dom_clk[i]) disable iff (!ext_rst_n)
        (mode_q && $rose(chain[LAST])) |-> rel[i-1]);
    end

    always_ff @(posedge dom_clk[i] or negedge ext_rst_n)
      if (!ext_rst_n) chain <= '0;
      else            chain <= {chain[STAGES-2:0], feed};

    always_ff @(posedge dom_clk[i])
      if (!chain[0]) mode_q <= ordered_mode;

    assign rel[i]       = chain[LAST];
    assign dom_rst_n[i] = chain[LAST] | test_mode;

    assert_hold_low_R1: assert property (@(posedge dom_clk[i])
      (!ext_rst_n && !test_mode) |-> !dom_rst_n[i]);

    assert_two_stage_R2: assert property (@(posedge dom_clk[i]) disable iff (!ext_rst_n)
      $rose(chain[LAST]) |-> $past(chain[LAST-1]));

    assert_mode_frozen_R7: assert property (@(posedge dom_clk[i]) disable iff (!ext_rst_n)
      chain[0] |=> $stable(mode_q));
  end
endmodule

// File: tb/sim_reset_sequencer.sv
module sim_reset_sequencer;
  timeunit 1ns;
  timeprecision 10ps;

  logic       c0 = 1'b0, c1 = 1'b0, c2 = 1'b0;
  logic       ext_rst_n = 1'b1;
  logic       ordered_mode = 1'b1;
  logic       test_mode = 1'b0;
  logic [2:0] dom_rst_n;
  logic [2:0] dom_clk;
  real        h1 = 3.0, h2 = 5.0;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  assign dom_clk = {c2, c1, c0};

  reset_sequencer u0 (
    .ext_rst_n(ext_rst_n), .dom_clk(dom_clk), .ordered_mode(ordered_mode),
    .test_mode(test_mode), .dom_rst_n(dom_rst_n));

  initial forever #2 c0 = ~c0;
  initial begin #0.25; forever #(h1) c1 = ~c1; end
  initial begin #0.5;  forever #(h2) c2 = ~c2; end

  task automatic chk(bit ok, string req, logic [2:0] act, logic [2:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic edge_of(int i);
    case (i)
      0: @(posedge c0);
      1: @(posedge c1);
      default: @(posedge c2);
    endcase
  endtask

  task automatic rise_of(int i);
    case (i)
      0: @(posedge dom_rst_n[0]);
      1: @(posedge dom_rst_n[1]);
      default: @(posedge dom_rst_n[2]);
    endcase
  endtask

  task automatic align();
    @(posedge c0);
    #0.7;
  endtask

  // Trigger, then two own-clock edges: low after first, high after second (R2, R3/R4)
  task automatic watch(int i, bit ord);
    string tag;
    tag = ord ? "R3" : "R4";
    if (ord && i > 0) rise_of(i - 1);
    edge_of(i); #0.1;
    chk(dom_rst_n[i] == 1'b0, "R2", {2'b0, dom_rst_n[i]}, 3'b000);
    edge_of(i); #0.1;
    chk(dom_rst_n[i] == 1'b1, tag, {2'b0, dom_rst_n[i]}, 3'b001);
  endtask

  task automatic enter_reset(bit ord);
    ordered_mode = ord;
    align();
    ext_rst_n = 1'b0;
    #0.1;
    chk(dom_rst_n == 3'b000, "R1", dom_rst_n, 3'b000);
    #30;
  endtask

  task automatic release_and_watch(bit ord);
    align();
    ext_rst_n = 1'b1;
    fork
      watch(0, ord);
      watch(1, ord);
      watch(2, ord);
    join
    chk(dom_rst_n == 3'b111, ord ? "R3" : "R4", dom_rst_n, 3'b111);
  endtask

  initial begin
    void'($urandom(32'd7001));
    #1;
    ext_rst_n = 1'b0;
    #0.1;
    chk(dom_rst_n == 3'b000, "R1", dom_rst_n, 3'b000);
    #30;

    // directed: ordered with equal-ish fast clocks, then unordered
    h1 = 1.0; h2 = 1.0;
    enter_reset(1'b1); release_and_watch(1'b1);
    enter_reset(1'b0); release_and_watch(1'b0);

    // directed: slow followers, fast head
    h1 = 6.0; h2 = 6.0;
    enter_reset(1'b1); release_and_watch(1'b1);

    // R7: flipping mode after release leaves outputs untouched
    ordered_mode = 1'b0;
    #50;
    chk(dom_rst_n == 3'b111, "R7", dom_rst_n, 3'b111);
    ordered_mode = 1'b1;
    #50;
    chk(dom_rst_n == 3'b111, "R7", dom_rst_n, 3'b111);

    // R6: reassert just after domain 0 leaves reset, lower domains mid-chain
    h1 = 6.0; h2 = 5.0;
    enter_reset(1'b1);
    align();
    ext_rst_n = 1'b1;
    rise_of(0);
    #0.3;
    ext_rst_n = 1'b0;
    #0.1;
    chk(dom_rst_n == 3'b000, "R6", dom_rst_n, 3'b000);
    #40;
    chk(dom_rst_n == 3'b000, "R6", dom_rst_n, 3'b000);
    release_and_watch(1'b1);

    // R5: test mode overrides reset
    enter_reset(1'b1);
    test_mode = 1'b1;
    #0.1;
    chk(dom_rst_n == 3'b111, "R5", dom_rst_n, 3'b111);
    #30;
    chk(dom_rst_n == 3'b111, "R5", dom_rst_n, 3'b111);
    test_mode = 1'b0;
    #0.1;
    chk(dom_rst_n == 3'b000, "R5", dom_rst_n, 3'b000);
    release_and_watch(1'b1);

    // random frequency ratios and modes
    for (int t = 0; t < 12; t++) begin
      bit ord;
      ord = 1'($urandom % 2);
      h1 = real'(1 + $urandom % 6);
      h2 = real'(1 + $urandom % 6);
      enter_reset(ord);
      release_and_watch(ord);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #150000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule